// File: doc/BRIEF.md
# Out-of-Order Task Scheduling Window

The block keeps a small window of task descriptors. The descriptors arrive in program order. Each descriptor carries a task ID, up to two read ranges, up to two write ranges, and a flag for tasks whose footprint cannot be bounded. When a descriptor is accepted, its ranges are compared in one cycle against the ranges of every task still held in the window. The block records each older task that the new task must wait for.

Tasks whose upstream tasks have all finished are handed to a fixed pool of execution slots. Tasks may leave in any order. Each slot runs one task at a time. A slot asks for work with a request line and receives a one-cycle grant together with the task ID. It reports completion with a done strobe that carries its slot index. Completion frees the slot and the window entry at the same edge, and it releases every task that was waiting only on the finished task.

Top module: `task_sched_window`

## Requirements
- R1: `in_ready_o` is high exactly when at least one of the WIN entries is free. A descriptor is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high. A descriptor offered while `in_ready_o` is low is ignored and never granted.
- R2: A range is a start address and a length. It covers the addresses from start to start+length-1. Two ranges overlap when start_a < start_b+len_b and start_b < start_a+len_a. A range of length zero overlaps nothing.
- R3: A new task depends on an older task in the window when an overlap exists for any of these pairs:
  - a read range of the new task against a write range of the older task;
  - a write range of the new task against a read range of the older task;
  - a write range of the new task against a write range of the older task.
  Any of the two read slots (index 0 and 1) and any of the two write slots can take part. Two reads never conflict.
- R4: A task with `in_all_mem_i` set is treated as reading every address. It depends on every older task that has a write range of nonzero length. Every later task with such a write range depends on it.
- R5: A task is never granted while any task it depends on is still in the window. The task becomes grantable on the cycle after the done strobe of its last upstream task.
- R6: A slot with `slot_req_i` high and no task in flight receives a grant in the same cycle if any task is Ready. `grant_id_o` shows the ID of that task. Each task is granted exactly once.
- R7: Among Ready tasks, the one accepted earliest is granted first. This holds whatever window position each task occupies. When several slots can take work in one cycle, the lowest-numbered slot receives the oldest task.
- R8: `done_valid_i` with a slot index retires that slot's task and frees its entry at the same edge. The slot gets no grant in the cycle of its done strobe. It can be granted again from the next cycle, and the freed entry can accept a new descriptor from the next cycle.
- R9: After reset the window is empty: `in_ready_o` is high and no grant is issued even when every slot requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Descriptor offered |
| in_ready_o | output | 1 | Window has a free entry |
| in_id_i | input | IDW | Task ID |
| in_all_mem_i | input | 1 | Task reads all of memory |
| in_rd_start_i | input | NR*AW | Read range starts, range r at bits [r*AW +: AW] |
| in_rd_len_i | input | NR*LW | Read range lengths, range r at bits [r*LW +: LW] |
| in_wr_start_i | input | NW*AW | Write range starts, range w at bits [w*AW +: AW] |
| in_wr_len_i | input | NW*LW | Write range lengths, range w at bits [w*LW +: LW] |
| slot_req_i | input | SLOTS | Per-slot request for work |
| grant_o | output | SLOTS | Per-slot grant, one cycle |
| grant_id_o | output | SLOTS*IDW | Granted task ID, slot s at bits [s*IDW +: IDW] |
| done_valid_i | input | 1 | A slot finished its task |
| done_slot_i | input | SIW | Index of the finishing slot |

## Verification
The failure modes show up at the ports as follows:

- **Lost dependency bit.** A conflicting task is granted alongside its producer in the very cycle both slots request. The sweep over range placements catches this on the first grant after the second descriptor.
- **Stuck dependency bit.** A task is never granted after its producer retires. This shows up as a missing grant one cycle after the done strobe.
- **Corrupted age order or slot bookkeeping.** This appears as the wrong `grant_id_o` on the slot, or as a grant to a slot in the same cycle as its done strobe. Both are visible in the cycle where the fault occurs.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_PEND = 2'd1,
    ST_RDY  = 2'd2,
    ST_EXEC = 2'd3
  } ent_state_e;
endpackage

// File: rtl/tsw_range_store.sv
module tsw_range_store #(
  parameter int unsigned WIN = 4,
  parameter int unsigned NR  = 2,
  parameter int unsigned NW  = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned LW  = 4,
  localparam int unsigned EIW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [EIW-1:0]   widx_i,
  input  logic             all_i,
  input  logic [NR*AW-1:0] rs_i,
  input  logic [NR*LW-1:0] rl_i,
  input  logic [NW*AW-1:0] ws_i,
  input  logic [NW*LW-1:0] wl_i,
  output logic [WIN-1:0]   conflict_o
);
  localparam int unsigned SW = ((AW > LW) ? AW : LW) + 1;

  logic [AW-1:0] rs_q [WIN][NR];
  logic [LW-1:0] rl_q [WIN][NR];
  logic [AW-1:0] ws_q [WIN][NW];
  logic [LW-1:0] wl_q [WIN][NW];
  logic [WIN-1:0] all_q;

  function automatic logic ovl(logic [AW-1:0] sa, logic [LW-1:0] la,
                               logic [AW-1:0] sb, logic [LW-1:0] lb);
    logic [SW-1:0] a0, b0, a1, b1;
    a0 = SW'(sa);
    b0 = SW'(sb);
    a1 = a0 + SW'(la);
    b1 = b0 + SW'(lb);
    return (la != '0) && (lb != '0) && (a0 < b1) && (b0 < a1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      all_q <= '0;
      for (int e = 0; e < WIN; e++) begin
        for (int r = 0; r < NR; r++) begin
          rs_q[e][r] <= '0;
          rl_q[e][r] <= '0;
        end
        for (int w = 0; w < NW; w++) begin
          ws_q[e][w] <= '0;
          wl_q[e][w] <= '0;
        end
      end
    end else if (we_i) begin
      all_q[widx_i] <= all_i;
      for (int r = 0; r < NR; r++) begin
        rs_q[widx_i][r] <= rs_i[r*AW +: AW];
        rl_q[widx_i][r] <= rl_i[r*LW +: LW];
      end
      for (int w = 0; w < NW; w++) begin
        ws_q[widx_i][w] <= ws_i[w*AW +: AW];
        wl_q[widx_i][w] <= wl_i[w*LW +: LW];
      end
    end
  end

  logic new_wr;
  logic [WIN-1:0] old_wr;

  always_comb begin
    new_wr = 1'b0;
    for (int w = 0; w < NW; w++) new_wr |= (wl_i[w*LW +: LW] != '0);
    for (int e = 0; e < WIN; e++) begin
      old_wr[e] = 1'b0;
      for (int w = 0; w < NW; w++) old_wr[e] |= (wl_q[e][w] != '0);
      // whole-memory reader against any writer
      conflict_o[e] = (all_i & old_wr[e]) | (all_q[e] & new_wr);
      for (int w = 0; w < NW; w++) begin
        for (int r = 0; r < NR; r++) begin
          conflict_o[e] |= ovl(rs_i[r*AW +: AW], rl_i[r*LW +: LW], ws_q[e][w], wl_q[e][w]);
        end
        for (int r = 0; r < NR; r++) begin
          conflict_o[e] |= ovl(ws_i[w*AW +: AW], wl_i[w*LW +: LW], rs_q[e][r], rl_q[e][r]);
        end
        for (int v = 0; v < NW; v++) begin
          conflict_o[e] |= ovl(ws_i[w*AW +: AW], wl_i[w*LW +: LW], ws_q[e][v], wl_q[e][v]);
        end
      end
    end
  end
endmodule

// File: rtl/tsw_issue_arb.sv
module tsw_issue_arb #(
  parameter int unsigned WIN   = 4,
  parameter int unsigned SLOTS = 2,
  localparam int unsigned EIW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [SLOTS-1:0]         req_i,
  input  logic [WIN-1:0]           rdy_i,
  input  logic [WIN-1:0][WIN-1:0]  older_i,
  output logic [SLOTS-1:0]         take_o,
  output logic [EIW-1:0]           sel_o [SLOTS],
  output logic [WIN-1:0]           taken_o
);
  logic [WIN-1:0] avail;

  always_comb begin
    avail   = rdy_i;
    taken_o = '0;
    for (int s = 0; s < SLOTS; s++) begin
      take_o[s] = 1'b0;
      sel_o[s]  = '0;
      if (req_i[s]) begin
        for (int i = 0; i < WIN; i++) begin
          // oldest: no older entry is still available
          if (!take_o[s] && avail[i] && ((older_i[i] & avail) == '0)) begin
            take_o[s] = 1'b1;
            sel_o[s]  = EIW'(i);
          end
        end
        if (take_o[s]) begin
          avail[sel_o[s]]   = 1'b0;
          taken_o[sel_o[s]] = 1'b1;
        end
      end
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_chk
    p_take_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o[s] |-> rdy_i[sel_o[s]]);
    for (genvar t = s + 1; t < SLOTS; t++) begin : g_pair
      p_sel_distinct_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (take_o[s] && take_o[t]) |-> (sel_o[s] != sel_o[t]));
      p_low_slot_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i[s] && take_o[t]) |-> take_o[s]);
    end
  end
endmodule

// File: rtl/task_sched_window.sv
module task_sched_window
  import tsw_pkg::*;
#(
  parameter int unsigned WIN   = 4,
  parameter int unsigned SLOTS = 2,
  parameter int unsigned NR    = 2,
  parameter int unsigned NW    = 2,
  parameter int unsigned AW    = 8,
  parameter int unsigned LW    = 4,
  parameter int unsigned IDW   = 4,
  localparam int unsigned EIW = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int unsigned SIW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic [IDW-1:0]       in_id_i,
  input  logic                 in_all_mem_i,
  input  logic [NR*AW-1:0]     in_rd_start_i,
  input  logic [NR*LW-1:0]     in_rd_len_i,
  input  logic [NW*AW-1:0]     in_wr_start_i,
  input  logic [NW*LW-1:0]     in_wr_len_i,
  input  logic [SLOTS-1:0]     slot_req_i,
  output logic [SLOTS-1:0]     grant_o,
  output logic [SLOTS*IDW-1:0] grant_id_o,
  input  logic                 done_valid_i,
  input  logic [SIW-1:0]       done_slot_i
);
  ent_state_e               st_q [WIN];
  logic [WIN-1:0][WIN-1:0]  dep_q, older_q;
  logic [IDW-1:0]           id_q [WIN];
  logic [SLOTS-1:0]         busy_q;
  logic [EIW-1:0]           sent_q [SLOTS];

  logic [WIN-1:0] used, rdy, conflict, ret_mask, taken, dep_new;
  logic [EIW-1:0] alloc_idx;
  logic [EIW-1:0] sel [SLOTS];
  logic           has_free, acc;

  always_comb begin
    has_free  = 1'b0;
    alloc_idx = '0;
    for (int i = WIN - 1; i >= 0; i--) begin
      used[i] = (st_q[i] != ST_FREE);
      rdy[i]  = (st_q[i] == ST_RDY);
      if (!used[i]) begin
        has_free  = 1'b1;
        alloc_idx = EIW'(i);
      end
    end
  end

  assign in_ready_o = has_free;
  assign acc        = in_valid_i & has_free;
  assign ret_mask   = done_valid_i ? (WIN'(1) << sent_q[done_slot_i]) : '0;
  assign dep_new    = conflict & used & ~ret_mask;

  tsw_range_store #(.WIN(WIN), .NR(NR), .NW(NW), .AW(AW), .LW(LW)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (acc),
    .widx_i     (alloc_idx),
    .all_i      (in_all_mem_i),
    .rs_i       (in_rd_start_i),
    .rl_i       (in_rd_len_i),
    .ws_i       (in_wr_start_i),
    .wl_i       (in_wr_len_i),
    .conflict_o (conflict)
  );

  tsw_issue_arb #(.WIN(WIN), .SLOTS(SLOTS)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (slot_req_i & ~busy_q),
    .rdy_i   (rdy),
    .older_i (older_q),
    .take_o  (grant_o),
    .sel_o   (sel),
    .taken_o (taken)
  );

  always_comb begin
    for (int s = 0; s < SLOTS; s++) grant_id_o[s*IDW +: IDW] = id_q[sel[s]];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dep_q   <= '0;
      older_q <= '0;
      for (int i = 0; i < WIN; i++) begin
        st_q[i] <= ST_FREE;
        id_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < WIN; i++) begin
        dep_q[i] <= dep_q[i] & ~ret_mask;
        if (acc && alloc_idx != EIW'(i)) older_q[i][alloc_idx] <= 1'b0;
        if (ret_mask[i]) begin
          st_q[i] <= ST_FREE;
        end else if (acc && alloc_idx == EIW'(i)) begin
          st_q[i]    <= (dep_new == '0) ? ST_RDY : ST_PEND;
          dep_q[i]   <= dep_new;
          older_q[i] <= used & ~ret_mask;
          id_q[i]    <= in_id_i;
        end else if (taken[i]) begin
          st_q[i] <= ST_EXEC;
        end else if (st_q[i] == ST_PEND && (dep_q[i] & ~ret_mask) == '0) begin
          st_q[i] <= ST_RDY;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= '0;
      for (int s = 0; s < SLOTS; s++) sent_q[s] <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (grant_o[s]) begin
          busy_q[s] <= 1'b1;
          sent_q[s] <= sel[s];
        end else if (done_valid_i && done_slot_i == SIW'(s)) begin
          busy_q[s] <= 1'b0;
        end
      end
    end
  end

  p_done_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_valid_i |-> busy_q[done_slot_i]);

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot_chk
    p_no_regrant_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_valid_i && done_slot_i == SIW'(s)) |-> !grant_o[s]);
    p_grant_free_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[s] |-> (dep_q[sel[s]] == '0));
  end

  for (genvar i = 0; i < WIN; i++) begin : g_ent_chk
    p_exec_nodep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] == ST_EXEC) |-> (dep_q[i] == '0));
    p_dep_older_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dep_q[i] & ~older_q[i]) == '0);
  end
endmodule

// File: tb/task_sched_window_tb_top.sv
module task_sched_window_tb_top;
  localparam int unsigned NR = 2, NW = 2, AW = 8, LW = 4, IDW = 4, SLOTS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IDW-1:0] in_id = '0;
  logic in_all = 1'b0;
  logic [NR*AW-1:0] rs = '0;
  logic [NR*LW-1:0] rl = '0;
  logic [NW*AW-1:0] ws = '0;
  logic [NW*LW-1:0] wl = '0;
  logic [SLOTS-1:0] req = '0;
  logic [SLOTS-1:0] gnt;
  logic [SLOTS*IDW-1:0] gid;
  logic done_v = 1'b0;
  logic done_s = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  task_sched_window dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_id_i(in_id), .in_all_mem_i(in_all),
    .in_rd_start_i(rs), .in_rd_len_i(rl), .in_wr_start_i(ws), .in_wr_len_i(wl),
    .slot_req_i(req), .grant_o(gnt), .grant_id_o(gid),
    .done_valid_i(done_v), .done_slot_i(done_s)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int id, bit all, int rs0, int rl0, int rs1, int rl1,
                      int ws0, int wl0, int ws1, int wl1);
    in_valid = 1'b1;
    in_id = IDW'(id);
    in_all = all;
    rs = {AW'(rs1), AW'(rs0)};
    rl = {LW'(rl1), LW'(rl0)};
    ws = {AW'(ws1), AW'(ws0)};
    wl = {LW'(wl1), LW'(wl0)};
    step();
    in_valid = 1'b0;
    in_all = 1'b0;
    rl = '0;
    wl = '0;
  endtask

  task automatic done(int s);
    done_v = 1'b1;
    done_s = s[0];
    step();
    done_v = 1'b0;
  endtask

  function automatic int gid_of(int s);
    return int'(gid[s*IDW +: IDW]);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    #1;
    // R9 reset state
    req = 2'b11;
    #1;
    check("R9 in_ready", int'(in_ready), 1);
    check("R9 no grant", int'(gnt), 0);
    req = 2'b00;
    step();

    // R2 R3 sweep: A then B, both slots request
    for (int kind = 0; kind < 4; kind++) begin
      for (int as = 0; as < 8; as++) begin
        for (int al = 0; al < 4; al++) begin
          for (int bs = 0; bs < 8; bs++) begin
            for (int bl = 0; bl < 4; bl++) begin
              bit conf;
              conf = (kind != 2) && (al != 0) && (bl != 0) && (as < bs + bl) && (bs < as + al);
              case (kind)
                0: begin push(1, 0, 0, 0, 0, 0, as, al, 0, 0); push(2, 0, bs, bl, 0, 0, 0, 0, 0, 0); end
                1: begin push(1, 0, as, al, 0, 0, 0, 0, 0, 0); push(2, 0, 0, 0, 0, 0, bs, bl, 0, 0); end
                2: begin push(1, 0, as, al, 0, 0, 0, 0, 0, 0); push(2, 0, 0, 0, bs, bl, 0, 0, 0, 0); end
                default: begin push(1, 0, 0, 0, 0, 0, 0, 0, as, al); push(2, 0, 0, 0, 0, 0, bs, bl, 0, 0); end
              endcase
              req = 2'b11;
              #1;
              check("R3 first grant", int'(gnt), conf ? 1 : 3);
              check("R6 slot0 id", gid_of(0), 1);
              if (!conf) check("R2 slot1 id", gid_of(1), 2);
              step();
              req = 2'b00;
              done(0);
              if (!conf) begin
                done(1);
              end else begin
                req = 2'b11;
                #1;
                check("R5 released grant", int'(gnt), 1);
                check("R5 released id", gid_of(0), 2);
                step();
                req = 2'b00;
                done(0);
              end
            end
          end
        end
      end
    end

    // R1 fill window, R7 age order, R8 done timing
    push(1, 0, 0, 0, 0, 0, 0, 4, 0, 0);
    push(2, 0, 0, 0, 0, 0, 16, 4, 0, 0);
    push(3, 0, 0, 0, 0, 0, 32, 4, 0, 0);
    push(4, 0, 0, 0, 0, 0, 48, 4, 0, 0);
    check("R1 full not ready", int'(in_ready), 0);
    in_valid = 1'b1;
    in_id = 4'd9;
    step();
    in_valid = 1'b0;
    check("R1 still full", int'(in_ready), 0);
    req = 2'b11;
    #1;
    check("R7 two grants", int'(gnt), 3);
    check("R7 oldest slot0", gid_of(0), 1);
    check("R7 next slot1", gid_of(1), 2);
    step();
    done_v = 1'b1;
    done_s = 1'b1;
    #1;
    check("R8 no grant in done cycle", int'(gnt), 0);
    step();
    done_v = 1'b0;
    #1;
    check("R8 regrant next cycle", int'(gnt), 2);
    check("R7 oldest remaining", gid_of(1), 3);
    step();
    req = 2'b00;
    check("R8 entry freed", int'(in_ready), 1);
    push(5, 0, 0, 0, 0, 0, 64, 4, 0, 0);
    done(0);
    done(1);
    req = 2'b11;
    #1;
    check("R7 age not position", int'(gnt), 3);
    check("R7 id4 first", gid_of(0), 4);
    check("R1 ignored id absent", gid_of(1), 5);
    step();
    req = 2'b00;
    done(0);
    done(1);

    // R4 whole-memory reader
    push(1, 0, 0, 0, 0, 0, 0, 2, 0, 0);
    push(2, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    push(3, 0, 8, 2, 0, 0, 0, 0, 0, 0);
    push(4, 0, 0, 0, 0, 0, 100, 1, 0, 0);
    req = 2'b11;
    #1;
    check("R4 reader passes, all-mem waits", int'(gnt), 3);
    check("R4 slot0 id", gid_of(0), 1);
    check("R4 slot1 id", gid_of(1), 3);
    step();
    req = 2'b00;
    done(1);
    req = 2'b11;
    #1;
    check("R5 nothing ready", int'(gnt), 0);
    req = 2'b00;
    done(0);
    req = 2'b11;
    #1;
    check("R4 all-mem granted", int'(gnt), 1);
    check("R4 all-mem id", gid_of(0), 2);
    step();
    #1;
    check("R5 writer waits on executing", int'(gnt), 0);
    done_v = 1'b1;
    done_s = 1'b0;
    #1;
    check("R5 not in done cycle", int'(gnt), 0);
    step();
    done_v = 1'b0;
    #1;
    check("R4 writer after all-mem", int'(gnt), 1);
    check("R5 writer id", gid_of(0), 4);
    step();
    req = 2'b00;
    done(0);

    // R3 second range slots
    push(6, 0, 0, 0, 0, 0, 0, 0, 40, 3);
    push(7, 0, 0, 0, 42, 1, 0, 0, 0, 0);
    req = 2'b11;
    #1;
    check("R3 index1 conflict", int'(gnt), 1);
    check("R3 index1 id", gid_of(0), 6);
    step();
    req = 2'b00;
    done(0);
    req = 2'b11;
    #1;
    check("R3 index1 release", gid_of(0), 7);
    step();
    req = 2'b00;
    done(0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule